// File: doc/BRIEF.md
# Destination Address Receive Filter

This block decides, for every incoming Ethernet frame, whether the receive path should keep it, judging only by the 48-bit destination address at the head of the frame. The address arrives one byte per cycle on a byte stream qualified by a valid strobe. Byte 0 of the address comes first. Gaps between bytes are allowed.

Three kinds of destination are handled differently. An individual (unicast) address must equal the programmed station address. A group (multicast) address is hashed with a bit-serial CRC-32. The top six bits of that CRC index a 64-bit acceptance mask. The all-ones broadcast address has its own enable. A promiscuous enable overrides all three.

The decision is delivered as a one-cycle strobe with an accept bit and a group-address flag. A start pulse rearms the filter for the next frame.

Top module: `rxaddr_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, `dec_vld_o`, `accept_o` and `grp_o` are all 0.
- R2: `dec_vld_o` rises in the cycle right after the sixth byte is taken and lasts exactly one cycle. It never rises after fewer than six bytes.
- R3: With `promisc_en_i` = 1 every frame is accepted, whatever its class and whatever the other enables and the mask hold.
- R4: A destination of all 48 ones is accepted if and only if `bcast_en_i` = 1 (or promiscuous is on). The multicast enable and the mask play no part for it.
- R5: Any other destination whose first byte has bit 0 set is accepted only when `mcast_en_i` = 1 and the mask bit is set. The hash is formed as follows. A 32-bit CRC is preset to all ones. For each address bit, taken byte 0 first and LSB first within a byte, compute carry = CRC[31] XOR data bit, then shift the CRC left by one. If carry is 1, XOR the CRC with 0x04C11DB6 and force bit 0 to 1. The index h is CRC[31:26] after 48 bits. The mask bit tested is bit h[2:0] of mask byte h[5:3], where mask byte k is `mcast_mask_i[8k+7:8k]`.
- R6: A destination whose first byte has bit 0 clear is accepted only if received byte k equals `station_addr_i[8k+7:8k]` for all k from 0 to 5.
- R7: `grp_o`, valid with `dec_vld_o`, equals bit 0 of the first destination byte. It is therefore also 1 for broadcast.
- R8: After the sixth byte, further bytes are ignored and produce no decision until `start_i` is pulsed. A byte presented in the same cycle as `start_i` is dropped.
- R9: Cycles with `byte_vld_i` = 0 between address bytes do not change the decision or its timing relative to the sixth byte.
- R10: A `start_i` pulse in the middle of an address discards the partial address. The next six bytes form a fresh address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; arms the filter like `start_i` |
| start_i | input | 1 | Rearm for a new frame: preset CRC, clear byte count |
| byte_vld_i | input | 1 | `byte_i` carries a destination byte this cycle |
| byte_i | input | 8 | Destination address byte, byte 0 first |
| station_addr_i | input | 48 | Own station address, byte k at bits [8k+7:8k] |
| mcast_mask_i | input | 64 | Multicast hash acceptance mask |
| promisc_en_i | input | 1 | Accept every frame |
| bcast_en_i | input | 1 | Accept the broadcast address |
| mcast_en_i | input | 1 | Accept hashed multicast addresses |
| dec_vld_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted (valid with `dec_vld_o`) |
| grp_o | output | 1 | Destination is a group address (valid with `dec_vld_o`) |

## Verification
The hardest situation to reach is a single-bit mask hit. Only one of the 64 mask bits may decide the outcome, and which bit that is depends on 48 serial CRC steps. The bench computes the hash index for a multicast address on its own. It then programs a mask holding exactly that bit, and the frame must be accepted. Next it programs masks whose only bit sits at the neighbouring bit position or in the neighbouring byte, and the frame must be rejected. This pins both the index value and how the index splits into byte and bit. Restart corner cases are reached by pulsing start mid-address and together with a byte, then sending a full station address that only matches if the dropped bytes were really discarded.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int          OCTET_W  = 8;
    localparam int          CRC_W    = 32;
    localparam int          HASH_W   = 6;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB6;

    typedef enum logic [1:0] {
        DST_UNICAST = 2'd0,
        DST_GROUP   = 2'd1,
        DST_BCAST   = 2'd2
    } dst_class_e;

    typedef struct packed {
        logic promisc;
        logic bcast;
        logic mcast;
    } rx_cfg_t;

    // Eight serial CRC steps over one octet, LSB first.
    function automatic logic [CRC_W-1:0] crc_octet(input logic [CRC_W-1:0] seed,
                                                   input logic [OCTET_W-1:0] dat);
        logic [CRC_W-1:0] c;
        logic             cy;
        c = seed;
        for (int j = 0; j < OCTET_W; j++) begin
            cy = c[CRC_W-1] ^ dat[j];
            c  = {c[CRC_W-2:0], 1'b0};
            if (cy) c = (c ^ CRC_POLY) | 32'h1;
        end
        return c;
    endfunction

    function automatic dst_class_e classify(input logic grp, input logic ones);
        if (ones)     return DST_BCAST;
        else if (grp) return DST_GROUP;
        else          return DST_UNICAST;
    endfunction

    function automatic logic decide(input rx_cfg_t cfg, input dst_class_e cls,
                                    input logic hit, input logic eq);
        if (cfg.promisc) return 1'b1;
        case (cls)
            DST_BCAST: return cfg.bcast;
            DST_GROUP: return cfg.mcast & hit;
            default:   return eq;
        endcase
    endfunction

endpackage

// File: rtl/rxf_hash_unit.sv
module rxf_hash_unit
    import rxf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_i,
    input  logic               take_i,
    input  logic [OCTET_W-1:0] byte_i,
    output logic [HASH_W-1:0]  idx_nxt_o
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;

    assign crc_nxt   = crc_octet(crc_q, byte_i);
    assign idx_nxt_o = crc_nxt[CRC_W-1 -: HASH_W];

    always_ff @(posedge clk) begin
        if (rst || clear_i) crc_q <= '1;
        else if (take_i)    crc_q <= crc_nxt;
    end

    // R9
    crc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!take_i && !clear_i) |=> $stable(crc_q));

endmodule

// File: rtl/rxf_dest_cmp.sv
module rxf_dest_cmp
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int POS_W      = 3
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear_i,
    input  logic                          take_i,
    input  logic [POS_W-1:0]              pos_i,
    input  logic [OCTET_W-1:0]            byte_i,
    input  logic [ADDR_BYTES*OCTET_W-1:0] station_i,
    output logic                          eq_nxt_o,
    output logic                          ones_nxt_o
);

    logic                eq_q;
    logic                ones_q;
    logic [OCTET_W-1:0]  stn_byte;

    assign stn_byte   = station_i[pos_i*OCTET_W +: OCTET_W];
    assign eq_nxt_o   = eq_q & (byte_i == stn_byte);
    assign ones_nxt_o = ones_q & (&byte_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            eq_q   <= 1'b1;
            ones_q <= 1'b1;
        end else if (take_i) begin
            eq_q   <= eq_nxt_o;
            ones_q <= ones_nxt_o;
        end
    end

    // R6
    eq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(eq_q) |-> $past(take_i));

endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic                          byte_vld_i,
    input  logic [7:0]                    byte_i,
    input  logic [ADDR_BYTES*8-1:0]       station_addr_i,
    input  logic [(1<<HASH_W)-1:0]        mcast_mask_i,
    input  logic                          promisc_en_i,
    input  logic                          bcast_en_i,
    input  logic                          mcast_en_i,
    output logic                          dec_vld_o,
    output logic                          accept_o,
    output logic                          grp_o
);

    localparam int POS_W = $clog2(ADDR_BYTES + 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);
    localparam logic [POS_W-1:0] DONE_POS = POS_W'(ADDR_BYTES);

    logic [POS_W-1:0]   pos_q;
    logic               grp_q;
    logic               take, first, last;
    logic [HASH_W-1:0]  idx_nxt;
    logic               eq_nxt, ones_nxt;
    logic [OCTET_W-1:0] mask_byte;
    logic               hit, grp_now;
    rx_cfg_t            cfg;
    dst_class_e         cls;

    assign take  = byte_vld_i && !start_i && (pos_q != DONE_POS);
    assign first = take && (pos_q == '0);
    assign last  = take && (pos_q == LAST_POS);

    rxf_hash_unit u_hash (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (start_i),
        .take_i   (take),
        .byte_i   (byte_i),
        .idx_nxt_o(idx_nxt)
    );

    rxf_dest_cmp #(.ADDR_BYTES(ADDR_BYTES), .POS_W(POS_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (start_i),
        .take_i    (take),
        .pos_i     (pos_q),
        .byte_i    (byte_i),
        .station_i (station_addr_i),
        .eq_nxt_o  (eq_nxt),
        .ones_nxt_o(ones_nxt)
    );

    // Mask byte by index[5:3], bit by index[2:0].
    assign mask_byte = mcast_mask_i[idx_nxt[HASH_W-1:3]*OCTET_W +: OCTET_W];
    assign hit       = mask_byte[idx_nxt[2:0]];
    assign grp_now   = first ? byte_i[0] : grp_q;
    assign cfg       = '{promisc: promisc_en_i, bcast: bcast_en_i, mcast: mcast_en_i};
    assign cls       = classify(grp_now, ones_nxt);

    always_ff @(posedge clk) begin
        if (rst || start_i) pos_q <= '0;
        else if (take)      pos_q <= pos_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)        grp_q <= 1'b0;
        else if (first) grp_q <= byte_i[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld_o <= 1'b0;
            accept_o  <= 1'b0;
            grp_o     <= 1'b0;
        end else begin
            dec_vld_o <= last;
            if (last) begin
                accept_o <= decide(cfg, cls, hit, eq_nxt);
                grp_o    <= grp_now;
            end
        end
    end

    // R2
    dec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dec_vld_o |=> !dec_vld_o);

    // R2
    dec_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        dec_vld_o |-> $past(byte_vld_i) && !$past(start_i));

    // R8
    pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q <= DONE_POS);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q == DONE_POS && !start_i) |=> !dec_vld_o);

endmodule

// File: tb/sim_rxaddr_filter.sv
`timescale 1ns/1ps
module sim_rxaddr_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [47:0] station_addr_i = 48'h6F5E_4D3C_1A02;
    logic [63:0] mcast_mask_i = '0;
    logic        promisc_en_i = 1'b0;
    logic        bcast_en_i = 1'b0;
    logic        mcast_en_i = 1'b0;
    logic        dec_vld_o, accept_o, grp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rxaddr_filter u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .station_addr_i(station_addr_i),
        .mcast_mask_i(mcast_mask_i), .promisc_en_i(promisc_en_i),
        .bcast_en_i(bcast_en_i), .mcast_en_i(mcast_en_i),
        .dec_vld_o(dec_vld_o), .accept_o(accept_o), .grp_o(grp_o)
    );

    // {dest, promisc, bcast_en, mcast_en, mask_all_ones, exp_accept, exp_grp}
    localparam int NV = 12;
    localparam logic [53:0] VEC [NV] = '{
        {48'h6F5E_4D3C_1A02, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {48'h705E_4D3C_1A02, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {48'h6F5E_4D3C_1A04, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {48'h1234_5678_9ABC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {48'h0000_005E_0001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {48'h0000_005E_0001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {48'h0000_005E_0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {48'h0000_005E_0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {48'h7FFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {48'h6F5E_4D3C_1A02, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    function automatic logic [5:0] ref_hash(input logic [47:0] d);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = r[31] ^ d[i];
            r = r << 1;
            if (fb) r = (r ^ 32'h04C1_1DB6) | 32'h1;
        end
        return r[31:26];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Sends six bytes; returns at the negedge where the decision is visible.
    task automatic send_addr(input logic [47:0] d, input bit gaps);
        for (int k = 0; k < 6; k++) begin
            byte_vld_i = 1'b1;
            byte_i     = d[8*k +: 8];
            @(negedge clk);
            byte_vld_i = 1'b0;
            if (k < 5) begin
                check("R2 early strobe", dec_vld_o, 1'b0);
                if (gaps) begin
                    @(negedge clk);
                    @(negedge clk);
                end
            end
        end
    endtask

    task automatic frame(input string tag, input logic [47:0] d, input bit gaps,
                         input logic ea, input logic eg);
        send_addr(d, gaps);
        check({tag, " strobe"}, dec_vld_o, 1'b1);
        check({tag, " accept"}, accept_o, ea);
        check({tag, " R7 grp"}, grp_o, eg);
        @(negedge clk);
        check("R2 pulse width", dec_vld_o, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [5:0]  h;
        logic [47:0] mc;
        repeat (3) @(negedge clk);
        check("R1 reset dec_vld", dec_vld_o, 1'b0);
        check("R1 reset accept", accept_o, 1'b0);
        check("R1 reset grp", grp_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset dec_vld", dec_vld_o, 1'b0);
        check("R1 after reset accept", accept_o, 1'b0);

        // Table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            logic [53:0] e = VEC[v];
            promisc_en_i = e[5];
            bcast_en_i   = e[4];
            mcast_en_i   = e[3];
            mcast_mask_i = e[2] ? '1 : '0;
            pulse_start();
            frame($sformatf("R3-6 vec%0d", v), e[53:6], 1'b0, e[1], e[0]);
        end

        // R5: single-bit mask at the computed hash index, and its neighbours
        mc = 48'h0000_005E_0001;
        h  = ref_hash(mc);
        promisc_en_i = 1'b0; bcast_en_i = 1'b0; mcast_en_i = 1'b1;
        mcast_mask_i = 64'h1 << h;
        pulse_start();
        frame("R5 exact bit", mc, 1'b0, 1'b1, 1'b1);
        mcast_mask_i = 64'h1 << (h ^ 6'h01);
        pulse_start();
        frame("R5 neighbour bit", mc, 1'b0, 1'b0, 1'b1);
        mcast_mask_i = 64'h1 << (h ^ 6'h08);
        pulse_start();
        frame("R5 neighbour byte", mc, 1'b0, 1'b0, 1'b1);
        mc = 48'hA1B2_C3D4_E5F7;
        h  = ref_hash(mc);
        mcast_mask_i = ~(64'h1 << h);
        pulse_start();
        frame("R5 only bit clear", mc, 1'b0, 1'b0, 1'b1);
        mcast_mask_i = 64'h1 << h;
        pulse_start();
        frame("R5 second addr hit", mc, 1'b0, 1'b1, 1'b1);

        // R9: idle cycles between bytes
        mcast_mask_i = '0; mcast_en_i = 1'b0;
        pulse_start();
        frame("R9 gapped unicast", station_addr_i, 1'b1, 1'b1, 1'b0);
        mcast_mask_i = 64'h1 << h; mcast_en_i = 1'b1;
        pulse_start();
        frame("R9 gapped multicast", mc, 1'b1, 1'b1, 1'b1);

        // R8: extra bytes without start give no decision
        send_addr(48'hFFFF_FFFF_FFFF, 1'b0);
        check("R8 no strobe after done", dec_vld_o, 1'b0);
        @(negedge clk);
        check("R8 no strobe after done late", dec_vld_o, 1'b0);
        check("R8 accept held", accept_o, 1'b1);

        // R8: byte coinciding with start is dropped
        mcast_en_i = 1'b0;
        start_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'hFF;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
        frame("R8 start byte dropped", station_addr_i, 1'b0, 1'b1, 1'b0);

        // R10: start mid-address discards partial bytes
        bcast_en_i = 1'b1;
        pulse_start();
        for (int k = 0; k < 3; k++) begin
            byte_vld_i = 1'b1; byte_i = 8'hFF;
            @(negedge clk);
        end
        byte_vld_i = 1'b0;
        pulse_start();
        frame("R10 restart unicast", station_addr_i, 1'b0, 1'b1, 1'b0);
        pulse_start();
        for (int k = 0; k < 4; k++) begin
            byte_vld_i = 1'b1; byte_i = station_addr_i[8*k +: 8];
            @(negedge clk);
        end
        byte_vld_i = 1'b0;
        pulse_start();
        frame("R10 restart broadcast", 48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1);

        finish_run();
    end

endmodule